// File: doc/BRIEF.md
# Storage Key Protection Checker

This block guards real storage with one protection entry per 4 KB frame. Each entry holds a 4-bit access key, a fetch-protect flag, a referenced flag and a changed flag. Every storage access presents its real address, the key taken from the current status word, a store/fetch indication and a low-address-protection enable. One cycle later the block answers permit or deny. A permitted access records itself in the frame's referenced flag, and a permitted store also records itself in the changed flag.

A maintenance port lets privileged software do three things: write a whole entry, read an entry back, or clear the referenced flag while returning the referenced and changed flags as they were just before the clear. Address translation and the data storage itself sit outside the block.

Top module: `skey_guard`

## Requirements
- R1: After reset every entry holds key 0 with all three flags clear, and `respValid` and `mntRdValid` are low.
- R2: `respValid` is high in exactly the cycle after a cycle with `reqValid` high. `respPermit` is low whenever `respValid` is low.
- R3: An access is permitted when `reqKey` equals the stored key of frame `reqAddr[ADDR_W-1:12]`. It is also permitted for any frame when `reqKey` is 0. Both cases are subject to R5.
- R4: On a key mismatch with nonzero `reqKey`, a store (`reqStore`=1) is denied. A fetch (`reqStore`=0) is denied only when the frame's fetch-protect flag is 1.
- R5: When `lapEnable` is 1, a store to real address 0..511 or 4096..4607 is denied, even with key 0. Fetches are not affected, and with `lapEnable` at 0 these addresses follow R3/R4.
- R6: A permitted access sets the frame's referenced flag. A permitted store also sets its changed flag. A denied access alters neither flag.
- R7: The value on `mntOp` selects the maintenance action: 0 writes the whole entry of `mntFrame` from `mntKey`, `mntFetchProt`, `mntRef` and `mntChg`; 1 reads the entry; 2 resets the referenced flag. For ops 1 and 2, `mntRdValid` is high in the next cycle with the entry's contents as they were before the edge.
- R8: Op 2 returns the old referenced and changed flags, clears the referenced flag, and leaves the key, the fetch-protect flag and the changed flag unchanged.
- R9: If op 0 or op 2 targets the frame that an access checks in the same cycle, the frame ends up holding the maintenance result. The access still gets its answer from the entry as it was before the edge.
- R10: Op 3 changes no entry and produces no `mntRdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access check request |
| reqAddr | input | ADDR_W | Real address of the access |
| reqKey | input | 4 | Requester key from the status word |
| reqStore | input | 1 | 1 = store, 0 = fetch |
| lapEnable | input | 1 | Low-address store protection enable |
| respValid | output | 1 | Check result valid |
| respPermit | output | 1 | 1 = access permitted |
| mntValid | input | 1 | Maintenance request |
| mntOp | input | 2 | 0 write entry, 1 read entry, 2 reset referenced, 3 none |
| mntFrame | input | ADDR_W-12 | Frame number addressed by maintenance |
| mntKey | input | 4 | Key written by op 0 |
| mntFetchProt | input | 1 | Fetch-protect flag written by op 0 |
| mntRef | input | 1 | Referenced flag written by op 0 |
| mntChg | input | 1 | Changed flag written by op 0 |
| mntRdValid | output | 1 | Maintenance read data valid |
| mntRdKey | output | 4 | Key read back |
| mntRdFetchProt | output | 1 | Fetch-protect flag read back |
| mntRdRef | output | 1 | Referenced flag read back (before clear for op 2) |
| mntRdChg | output | 1 | Changed flag read back |

## Verification
The bench builds the block with `ADDR_W` = 16, which gives 16 frames. With that size, the two protected low areas (frames 0 and 1) and ordinary frames can all be reached with short addresses. The 512-byte boundaries at 511/512 and 4607/4608 are probed directly. With only 16 frames, every entry can also be read back cheaply to confirm the flag side effects of permitted, denied and colliding accesses.

// File: rtl/skey_pkg.sv
package skey_pkg;

  typedef struct packed {
    logic [3:0] key;
    logic       fetchProt;
    logic       refBit;
    logic       chgBit;
  } entryT;

  typedef enum logic [1:0] {
    OP_SET_KEY    = 2'd0,
    OP_INSERT_KEY = 2'd1,
    OP_RESET_REF  = 2'd2,
    OP_NONE       = 2'd3
  } mntOpT;

  typedef struct packed {
    logic wrAll;
    logic clrRef;
    logic rdEntry;
    logic markRef;
    logic markChg;
  } strobeT;

  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned LOW_BITS  = 9;

endpackage

// File: rtl/skey_ctrl.sv
module skey_ctrl
  import skey_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned FRAME_W = ADDR_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [3:0]         reqKey,
  input  logic               reqStore,
  input  logic               lapEnable,
  input  logic               mntValid,
  input  logic [1:0]         mntOp,
  input  logic [FRAME_W-1:0] mntFrame,
  input  entryT              chkEntry,
  output logic [FRAME_W-1:0] chkFrame,
  output strobeT             stb,
  output logic               respValid,
  output logic               respPermit
);

  logic lowZone;
  logic keyMatch;
  logic permit;
  logic mntWrite;
  logic sameFrame;

  assign chkFrame = reqAddr[ADDR_W-1:PAGE_BITS];

  // frames 0 and 1, first 512 bytes of each
  assign lowZone  = (chkFrame <= FRAME_W'(1)) &&
                    (reqAddr[PAGE_BITS-1:LOW_BITS] == '0);
  assign keyMatch = (reqKey == 4'd0) || (reqKey == chkEntry.key);
  assign permit   = !(lapEnable && reqStore && lowZone) &&
                    (keyMatch || (!reqStore && !chkEntry.fetchProt));

  assign mntWrite  = mntValid && ((mntOp == OP_SET_KEY) || (mntOp == OP_RESET_REF));
  assign sameFrame = mntWrite && (mntFrame == chkFrame);

  always_comb begin
    stb         = '0;
    stb.wrAll   = mntValid && (mntOp == OP_SET_KEY);
    stb.clrRef  = mntValid && (mntOp == OP_RESET_REF);
    stb.rdEntry = mntValid && ((mntOp == OP_INSERT_KEY) || (mntOp == OP_RESET_REF));
    stb.markRef = reqValid && permit && !sameFrame;
    stb.markChg = reqValid && permit && reqStore && !sameFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respPermit <= 1'b0;
    end else begin
      respValid  <= reqValid;
      respPermit <= reqValid && permit;
    end
  end

endmodule

// File: rtl/skey_datapath.sv
module skey_datapath
  import skey_pkg::*;
#(
  parameter int unsigned FRAME_W    = 8,
  parameter int unsigned NUM_FRAMES = 1 << FRAME_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [FRAME_W-1:0] chkFrame,
  input  logic [FRAME_W-1:0] mntFrame,
  input  entryT              mntEntry,
  output entryT              chkEntry,
  output logic               rdValid,
  output entryT              rdEntry
);

  entryT frameTab [NUM_FRAMES];

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    entryT slot;
    logic  mntHit;
    logic  chkHit;

    assign mntHit = (mntFrame == FRAME_W'(f));
    assign chkHit = (chkFrame == FRAME_W'(f));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slot <= '0;
      end else if (stb.wrAll && mntHit) begin
        slot <= mntEntry;
      end else begin
        if (stb.clrRef && mntHit)  slot.refBit <= 1'b0;
        if (stb.markRef && chkHit) slot.refBit <= 1'b1;
        if (stb.markChg && chkHit) slot.chgBit <= 1'b1;
      end
    end

    assign frameTab[f] = slot;
  end

  assign chkEntry = frameTab[chkFrame];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdEntry <= '0;
    end else begin
      rdValid <= stb.rdEntry;
      if (stb.rdEntry) rdEntry <= frameTab[mntFrame];
    end
  end

endmodule

// File: rtl/skey_guard.sv
module skey_guard
  import skey_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [3:0]         reqKey,
  input  logic               reqStore,
  input  logic               lapEnable,
  output logic               respValid,
  output logic               respPermit,
  input  logic               mntValid,
  input  logic [1:0]         mntOp,
  input  logic [FRAME_W-1:0] mntFrame,
  input  logic [3:0]         mntKey,
  input  logic               mntFetchProt,
  input  logic               mntRef,
  input  logic               mntChg,
  output logic               mntRdValid,
  output logic [3:0]         mntRdKey,
  output logic               mntRdFetchProt,
  output logic               mntRdRef,
  output logic               mntRdChg
);

  strobeT             stb;
  entryT              chkEntry;
  entryT              rdEntry;
  entryT              mntEntry;
  logic [FRAME_W-1:0] chkFrame;

  assign mntEntry = '{key: mntKey, fetchProt: mntFetchProt, refBit: mntRef, chgBit: mntChg};

  skey_ctrl #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKey(reqKey), .reqStore(reqStore), .lapEnable(lapEnable),
    .mntValid(mntValid), .mntOp(mntOp), .mntFrame(mntFrame),
    .chkEntry(chkEntry), .chkFrame(chkFrame), .stb(stb),
    .respValid(respValid), .respPermit(respPermit)
  );

  skey_datapath #(.FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .chkFrame(chkFrame),
    .mntFrame(mntFrame), .mntEntry(mntEntry), .chkEntry(chkEntry),
    .rdValid(mntRdValid), .rdEntry(rdEntry)
  );

  assign mntRdKey       = rdEntry.key;
  assign mntRdFetchProt = rdEntry.fetchProt;
  assign mntRdRef       = rdEntry.refBit;
  assign mntRdChg       = rdEntry.chgBit;

endmodule

// File: rtl/skey_guard_chk.sv
module skey_guard_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [3:0]        reqKey,
  input logic              reqStore,
  input logic              lapEnable,
  input logic              respValid,
  input logic              respPermit,
  input logic              mntValid,
  input logic [1:0]        mntOp,
  input logic              mntRdValid
);

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);                                         // R2
  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);                                       // R2
  AST_PERMIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !respPermit);                                     // R2
  AST_KEY0_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKey == 4'd0 && !reqStore) |=> respPermit);       // R3
  AST_LOW_STORE_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && lapEnable && reqAddr < ADDR_W'(512)) |=> !respPermit); // R5
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (mntValid && (mntOp == 2'd1 || mntOp == 2'd2)) |=> mntRdValid);  // R7
  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!mntValid || mntOp == 2'd0 || mntOp == 2'd3) |=> !mntRdValid);  // R10

endmodule

bind skey_guard skey_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqKey(reqKey), .reqStore(reqStore), .lapEnable(lapEnable),
  .respValid(respValid), .respPermit(respPermit), .mntValid(mntValid),
  .mntOp(mntOp), .mntRdValid(mntRdValid)
);

// File: tb/skey_guard_bench.sv
module skey_guard_bench;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned FRAME_W = ADDR_W - 12;

  typedef struct packed {
    logic        isMnt;
    logic [1:0]  op;
    logic        store;
    logic        lap;
    logic [15:0] addr;
    logic [3:0]  key;
    logic        fp;
    logic [6:0]  expRd;   // {key, fetchProt, ref, chg}
    logic        expPermit;
  } vecT;

  localparam int NV = 23;
  localparam vecT VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 1'b0, 16'h3000, 4'd5, 1'b0, 7'h00, 1'b0}, // set frame3 key5
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h3000, 4'd0, 1'b0, {4'd5,3'b000}, 1'b0}, // R7
    '{1'b0, 2'd0, 1'b0, 1'b0, 16'h3010, 4'd5, 1'b0, 7'h00, 1'b1}, // R3 match fetch
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h3000, 4'd0, 1'b0, {4'd5,3'b010}, 1'b0}, // R6 ref
    '{1'b0, 2'd0, 1'b1, 1'b0, 16'h3020, 4'd7, 1'b0, 7'h00, 1'b0}, // R4 mismatch store
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h3000, 4'd0, 1'b0, {4'd5,3'b010}, 1'b0}, // R6 denied
    '{1'b0, 2'd0, 1'b0, 1'b0, 16'h3000, 4'd7, 1'b0, 7'h00, 1'b1}, // R4 fetch fp0
    '{1'b0, 2'd0, 1'b1, 1'b0, 16'h3004, 4'd5, 1'b0, 7'h00, 1'b1}, // R3 match store
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h3000, 4'd0, 1'b0, {4'd5,3'b011}, 1'b0}, // R6 chg
    '{1'b1, 2'd2, 1'b0, 1'b0, 16'h3000, 4'd0, 1'b0, {4'd5,3'b011}, 1'b0}, // R8 old
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h3000, 4'd0, 1'b0, {4'd5,3'b001}, 1'b0}, // R8 cleared
    '{1'b1, 2'd0, 1'b0, 1'b0, 16'h4000, 4'd9, 1'b1, 7'h00, 1'b0}, // set frame4 key9 fp
    '{1'b0, 2'd0, 1'b0, 1'b0, 16'h4000, 4'd2, 1'b0, 7'h00, 1'b0}, // R4 fp fetch deny
    '{1'b0, 2'd0, 1'b0, 1'b0, 16'h4000, 4'd0, 1'b0, 7'h00, 1'b1}, // R3 key0
    '{1'b0, 2'd0, 1'b1, 1'b1, 16'h0100, 4'd0, 1'b0, 7'h00, 1'b0}, // R5 low deny
    '{1'b0, 2'd0, 1'b1, 1'b0, 16'h0100, 4'd0, 1'b0, 7'h00, 1'b1}, // R5 disabled
    '{1'b0, 2'd0, 1'b1, 1'b1, 16'h11FF, 4'd0, 1'b0, 7'h00, 1'b0}, // R5 4607
    '{1'b0, 2'd0, 1'b1, 1'b1, 16'h1200, 4'd0, 1'b0, 7'h00, 1'b1}, // R5 4608
    '{1'b0, 2'd0, 1'b1, 1'b1, 16'h0200, 4'd0, 1'b0, 7'h00, 1'b1}, // R5 512
    '{1'b0, 2'd0, 1'b0, 1'b1, 16'h0000, 4'd0, 1'b0, 7'h00, 1'b1}, // R5 fetch ok
    '{1'b1, 2'd3, 1'b0, 1'b0, 16'h4000, 4'd0, 1'b0, 7'h00, 1'b0}, // R10 nop
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h4000, 4'd0, 1'b0, {4'd9,3'b110}, 1'b0}, // R10 / R6
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h0000, 4'd0, 1'b0, {4'd0,3'b011}, 1'b0}  // R6 frame0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqStore = 0, lapEnable = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [3:0] reqKey = '0;
  logic respValid, respPermit;
  logic mntValid = 0, mntFetchProt = 0, mntRef = 0, mntChg = 0;
  logic [1:0] mntOp = '0;
  logic [FRAME_W-1:0] mntFrame = '0;
  logic [3:0] mntKey = '0;
  logic mntRdValid, mntRdFetchProt, mntRdRef, mntRdChg;
  logic [3:0] mntRdKey;

  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  skey_guard #(.ADDR_W(ADDR_W)) u_skey_guard (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; mntValid = 0; reqStore = 0; lapEnable = 0;
  endtask

  function automatic logic [6:0] rd();
    return {mntRdKey, mntRdFetchProt, mntRdRef, mntRdChg};
  endfunction

  task automatic mnt(input logic [1:0] op, input logic [3:0] f, input logic [3:0] k, input logic fp);
    mntValid = 1; mntOp = op; mntFrame = f; mntKey = k; mntFetchProt = fp;
    mntRef = 0; mntChg = 0;
  endtask

  task automatic req(input logic [15:0] a, input logic [3:0] k, input logic st, input logic lap);
    reqValid = 1; reqAddr = a; reqKey = k; reqStore = st; lapEnable = lap;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 respValid", 32'(respValid), 0);
    chk("R1 mntRdValid", 32'(mntRdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    mnt(2'd1, 4'd7, 4'd0, 1'b0);
    @(negedge clk); idle();
    chk("R1 entry7 cleared", 32'(rd()), 0);
    chk("R7 read valid", 32'(mntRdValid), 1);

    foreach (VECS[i]) begin
      idle();
      if (VECS[i].isMnt) mnt(VECS[i].op, VECS[i].addr[15:12], VECS[i].key, VECS[i].fp);
      else req(VECS[i].addr, VECS[i].key, VECS[i].store, VECS[i].lap);
      @(negedge clk);
      idle();
      if (!VECS[i].isMnt) begin
        chk($sformatf("R2 vec%0d valid", i), 32'(respValid), 1);
        chk($sformatf("R3/R4/R5 vec%0d permit", i), 32'(respPermit), 32'(VECS[i].expPermit));
      end else if (VECS[i].op == 2'd1 || VECS[i].op == 2'd2) begin
        chk($sformatf("R7/R8 vec%0d read", i), 32'(rd()), 32'(VECS[i].expRd));
      end else begin
        chk($sformatf("R10 vec%0d no read", i), 32'(mntRdValid), 0);
      end
    end

    // R2 response drops after the request
    @(negedge clk);
    chk("R2 respValid idle", 32'(respValid), 0);
    chk("R2 respPermit idle", 32'(respPermit), 0);

    // R9 set-key collides with permitted store to frame 5
    mnt(2'd0, 4'd5, 4'd6, 1'b0);
    req(16'h5008, 4'd0, 1'b1, 1'b0);
    @(negedge clk); idle();
    chk("R9 collide permit", 32'(respPermit), 1);
    mnt(2'd1, 4'd5, 4'd0, 1'b0);
    @(negedge clk); idle();
    chk("R9 write wins", 32'(rd()), {4'd6, 3'b000});

    // R9 reset-reference collides with permitted fetch on frame 4 (ref currently 1)
    mnt(2'd2, 4'd4, 4'd0, 1'b0);
    req(16'h4010, 4'd9, 1'b0, 1'b0);
    @(negedge clk); idle();
    chk("R9/R8 old flags", 32'(rd()), {4'd9, 3'b110});
    chk("R9 fetch permit", 32'(respPermit), 1);
    mnt(2'd1, 4'd4, 4'd0, 1'b0);
    @(negedge clk); idle();
    chk("R9 clear wins", 32'(rd()), {4'd9, 3'b100});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule